// File: doc/BRIEF.md
# Program Counter and Return-Address Stack

This block keeps the instruction address of a small controller with a 9-bit program space. The address advances by one in every enabled instruction cycle. A jump can replace it with a full 9-bit target. A subroutine call or a computed write to the low address byte replaces only bits 7:0, and bit 8 is then forced to zero. Calls save the following address on a two-level return stack, and a return restores it.

The stack reports neither overflow nor underflow. A third nested call pushes the oldest saved address off the bottom. A return moves the second level up and leaves the bottom level unchanged, so returns beyond the stack depth keep producing that bottom address. After reset the address points at the last program word, and the first enabled cycle wraps it to zero. A parameter narrows the stored return addresses to 8 bits; in that variant bit 8 reads back as zero.

Top module: `flow_pc_unit`

## Requirements
- R1: While `rst` is high at a clock edge, that edge loads the address with 0x1FF and both stack levels with 0. This happens whatever the other inputs are.
- R2: When `step_en` is high and no request is asserted, the address increases by one at the next edge, and 0x1FF wraps to 0x000.
- R3: When `step_en` is low, the address and both stack levels hold their values, even if requests are asserted.
- R4: A granted jump (`goto_req`) loads all nine address bits from `target`.
- R5: A granted call (`call_req`) loads address bits 7:0 from `target[7:0]` and clears address bit 8.
- R6: A granted low-byte write (`pclw_req`) loads address bits 7:0 from `target[7:0]`, clears bit 8 and leaves the stack untouched.
- R7: A call moves level 1 into level 2 and writes the old address plus one (modulo 512) into level 1. After more than two nested calls only the two newest return addresses remain.
- R8: A granted return (`ret_req`) loads the address from level 1, copies level 2 into level 1 and keeps level 2, so further returns keep producing the level-2 address.
- R9: Only one operation is taken per enabled cycle. The order of precedence is return, then call, then jump, then low-byte write, then increment.
- R10: `pc_low` always equals bits 7:0 of `pc_q`.
- R11: When `STACK_W` is 8, the stack stores only bits 7:0 of each return address and reads bit 8 back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Instruction-cycle enable |
| ret_req | input | 1 | Return request |
| call_req | input | 1 | Call request |
| goto_req | input | 1 | Full-width jump request |
| pclw_req | input | 1 | Write of the low address byte |
| target | input | 9 | Jump target; bits 7:0 are used for call and low-byte write |
| pc_q | output | 9 | Current instruction address |
| pc_low | output | 8 | Low byte of the address |
| stk_lvl1 | output | 9 | Stack level 1 (next return address) |
| stk_lvl2 | output | 9 | Stack level 2 |

## Verification
The embedded assertions check the following on every cycle:
- the arithmetic of each operation that was granted: increment, jump, low-byte load with bit 8 cleared, and return;
- the shifting of the stack on a push and on a pop;
- that the address and the stack hold when the cycle is not enabled;
- the values loaded by reset.

Some behaviours appear only over a sequence of cycles, and only the bench scenarios can show them:
- the oldest return address being lost on the third nested call;
- the level-2 address being repeated after the stack has emptied;
- the wrap from 0x1FF to 0x000;
- the precedence between simultaneous requests;
- truncation in the 8-bit stack variant.

The bench checks these against a behavioural model, on both a default instance and a narrow-stack instance.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic [2:0] {
    OP_HOLD,
    OP_INC,
    OP_GOTO,
    OP_PCLW,
    OP_CALL,
    OP_RET
  } flow_op_e;
endpackage

// File: rtl/pcu_flow_arb.sv
module pcu_flow_arb
  import pcu_pkg::*;
(
  input  logic     en,
  input  logic     ret_req,
  input  logic     call_req,
  input  logic     goto_req,
  input  logic     pclw_req,
  output flow_op_e op
);
  always_comb begin
    if (!en)           op = OP_HOLD;
    else if (ret_req)  op = OP_RET;
    else if (call_req) op = OP_CALL;
    else if (goto_req) op = OP_GOTO;
    else if (pclw_req) op = OP_PCLW;
    else               op = OP_INC;
  end

  // R9
  always_comb begin
    if (op == OP_INC) begin
      inc_only_when_idle_chk: assert (!(ret_req || call_req || goto_req || pclw_req));
    end
    if (op == OP_HOLD) begin
      hold_only_when_off_chk: assert (!en);
    end
  end
endmodule

// File: rtl/pcu_pc_core.sv
module pcu_pc_core
  import pcu_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int LOW_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  flow_op_e          op,
  input  logic [ADDR_W-1:0] target,
  input  logic [ADDR_W-1:0] ret_addr,
  output logic [ADDR_W-1:0] pc_q,
  output logic [ADDR_W-1:0] pc_inc
);
  localparam logic [ADDR_W-1:0] RESET_PC = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] low_tgt;
  logic [ADDR_W-1:0] pc_d;

  always_comb begin
    low_tgt = '0;
    low_tgt[LOW_W-1:0] = target[LOW_W-1:0];
  end

  assign pc_inc = pc_q + ADDR_W'(1);

  always_comb begin
    case (op)
      OP_INC:  pc_d = pc_inc;
      OP_GOTO: pc_d = target;
      OP_PCLW: pc_d = low_tgt;
      OP_CALL: pc_d = low_tgt;
      OP_RET:  pc_d = ret_addr;
      default: pc_d = pc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_PC;
    else     pc_q <= pc_d;
  end

  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R1
  always @(posedge clk) begin
    if (rst_d) begin
      reset_pc_chk: assert (pc_q == RESET_PC);
    end
  end

  // R2
  inc_step_chk: assert property (@(posedge clk) disable iff (rst)
    op == OP_INC |=> pc_q == ADDR_W'($past(pc_q) + 1'b1));

  // R3
  hold_pc_chk: assert property (@(posedge clk) disable iff (rst)
    op == OP_HOLD |=> $stable(pc_q));

  // R4
  goto_load_chk: assert property (@(posedge clk) disable iff (rst)
    op == OP_GOTO |=> pc_q == $past(target));

  // R5 R6
  low_load_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_CALL || op == OP_PCLW) |=>
      (pc_q[ADDR_W-1:LOW_W] == '0 && pc_q[LOW_W-1:0] == $past(target[LOW_W-1:0])));

  // R8
  ret_load_chk: assert property (@(posedge clk) disable iff (rst)
    op == OP_RET |=> pc_q == $past(ret_addr));
endmodule

// File: rtl/pcu_ret_stack.sv
module pcu_ret_stack #(
  parameter int ADDR_W  = 9,
  parameter int STACK_W = 9,
  parameter int DEPTH   = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic                         pop,
  input  logic [ADDR_W-1:0]            push_val,
  output logic [DEPTH-1:0][ADDR_W-1:0] lvl
);
  logic [STACK_W-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst)       mem[i] <= '0;
        else if (push) mem[i] <= push_val[STACK_W-1:0];
        else if (pop)  mem[i] <= mem[i+1];
      end
    end else if (i == DEPTH-1) begin : g_tail
      always_ff @(posedge clk) begin
        if (rst)       mem[i] <= '0;
        else if (push) mem[i] <= mem[i-1];
      end
    end else begin : g_mid
      always_ff @(posedge clk) begin
        if (rst)       mem[i] <= '0;
        else if (push) mem[i] <= mem[i-1];
        else if (pop)  mem[i] <= mem[i+1];
      end
    end

    if (STACK_W < ADDR_W) begin : g_narrow
      assign lvl[i] = {{(ADDR_W-STACK_W){1'b0}}, mem[i]};
    end else begin : g_full
      assign lvl[i] = mem[i];
    end
  end

  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R1
  always @(posedge clk) begin
    if (rst_d) begin
      reset_stack_chk: assert (lvl[0] == '0 && lvl[DEPTH-1] == '0);
    end
  end

  // R7
  push_shift_chk: assert property (@(posedge clk) disable iff (rst)
    push |=> (lvl[0][STACK_W-1:0] == $past(push_val[STACK_W-1:0]) && lvl[1] == $past(lvl[0])));

  // R8
  pop_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !push) |=> (lvl[0] == $past(lvl[1]) && $stable(lvl[DEPTH-1])));

  // R3
  idle_stack_chk: assert property (@(posedge clk) disable iff (rst)
    (!push && !pop) |=> $stable(lvl));
endmodule

// File: rtl/flow_pc_unit.sv
module flow_pc_unit
  import pcu_pkg::*;
#(
  parameter int ADDR_W  = 9,
  parameter int LOW_W   = 8,
  parameter int STACK_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  input  logic              ret_req,
  input  logic              call_req,
  input  logic              goto_req,
  input  logic              pclw_req,
  input  logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] pc_q,
  output logic [LOW_W-1:0]  pc_low,
  output logic [ADDR_W-1:0] stk_lvl1,
  output logic [ADDR_W-1:0] stk_lvl2
);
  localparam int DEPTH = 2;

  flow_op_e                    op;
  logic [ADDR_W-1:0]           pc_inc;
  logic [DEPTH-1:0][ADDR_W-1:0] lvl;

  pcu_flow_arb u_arb (
    .en       (step_en),
    .ret_req  (ret_req),
    .call_req (call_req),
    .goto_req (goto_req),
    .pclw_req (pclw_req),
    .op       (op)
  );

  pcu_pc_core #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .target   (target),
    .ret_addr (lvl[0]),
    .pc_q     (pc_q),
    .pc_inc   (pc_inc)
  );

  pcu_ret_stack #(.ADDR_W(ADDR_W), .STACK_W(STACK_W), .DEPTH(DEPTH)) u_stack (
    .clk      (clk),
    .rst      (rst),
    .push     (op == OP_CALL),
    .pop      (op == OP_RET),
    .push_val (pc_inc),
    .lvl      (lvl)
  );

  assign pc_low   = pc_q[LOW_W-1:0];
  assign stk_lvl1 = lvl[0];
  assign stk_lvl2 = lvl[1];
endmodule

// File: tb/tb_flow_pc_unit.sv
module tb_flow_pc_unit;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst = 1'b1, en = 1'b0, ret = 1'b0, call = 1'b0, jmp = 1'b0, pclw = 1'b0;
  logic [8:0] tgt = '0;
  logic [8:0] pc_a, s1_a, s2_a, pc_b, s1_b, s2_b;
  logic [7:0] lo_a, lo_b;

  flow_pc_unit dut (
    .clk(clk), .rst(rst), .step_en(en), .ret_req(ret), .call_req(call),
    .goto_req(jmp), .pclw_req(pclw), .target(tgt),
    .pc_q(pc_a), .pc_low(lo_a), .stk_lvl1(s1_a), .stk_lvl2(s2_a));

  flow_pc_unit #(.STACK_W(8)) dut8 (
    .clk(clk), .rst(rst), .step_en(en), .ret_req(ret), .call_req(call),
    .goto_req(jmp), .pclw_req(pclw), .target(tgt),
    .pc_q(pc_b), .pc_low(lo_b), .stk_lvl1(s1_b), .stk_lvl2(s2_b));

  int total = 0, fails = 0;
  bit done = 0;
  int mp = 0, m1 = 0, m2 = 0;   // model, 9-bit stack
  int np = 0, n1 = 0, n2 = 0;   // model, 8-bit stack

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model(inout int pc, inout int s1, inout int s2, input int mask);
    if (rst) begin pc = 511; s1 = 0; s2 = 0; end
    else if (en) begin
      if (ret) begin pc = s1; s1 = s2; end
      else if (call) begin s2 = s1; s1 = ((pc + 1) % 512) & mask; pc = tgt & 255; end
      else if (jmp) pc = tgt;
      else if (pclw) pc = tgt & 255;
      else pc = (pc + 1) % 512;
    end
  endtask

  task automatic step(string tag, bit r, bit e, bit rt, bit c, bit g, bit w, int t);
    rst = r; en = e; ret = rt; call = c; jmp = g; pclw = w; tgt = t[8:0];
    model(mp, m1, m2, 511);
    model(np, n1, n2, 255);
    @(posedge clk);
    @(negedge clk);
    check(tag, pc_a, mp);
    check(tag, s1_a, m1);
    check(tag, s2_a, m2);
    check("R10", lo_a, mp & 255);
    check({tag, "/R11"}, pc_b, np);
    check({tag, "/R11"}, s1_b, n1);
    check({tag, "/R11"}, s2_b, n2);
    check("R10", lo_b, np & 255);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    step("R1", 1, 0, 0, 0, 0, 0, 0);
    step("R1", 1, 1, 1, 1, 1, 1, 9'h0AA);     // reset wins over everything
    step("R2", 0, 1, 0, 0, 0, 0, 0);          // 0x1FF wraps to 0x000
    step("R2", 0, 1, 0, 0, 0, 0, 0);
    step("R3", 0, 0, 1, 1, 1, 1, 9'h123);     // disabled: nothing moves
    step("R3", 0, 0, 0, 1, 0, 0, 9'h055);
    step("R4", 0, 1, 0, 0, 1, 0, 9'h1A5);
    step("R5", 0, 1, 0, 1, 0, 0, 9'h1C3);     // bit 8 cleared, push 0x1A6
    step("R7", 0, 1, 0, 1, 0, 0, 9'h010);
    step("R7", 0, 1, 0, 1, 0, 0, 9'h020);     // oldest dropped
    step("R8", 0, 1, 1, 0, 0, 0, 0);
    step("R8", 0, 1, 1, 0, 0, 0, 0);
    step("R8", 0, 1, 1, 0, 0, 0, 0);          // repeats level 2
    step("R6", 0, 1, 0, 0, 0, 1, 9'h1F0);
    step("R4", 0, 1, 0, 0, 1, 0, 9'h150);
    step("R11", 0, 1, 0, 1, 0, 0, 9'h020);    // narrow stores 0x51
    step("R11", 0, 1, 1, 0, 0, 0, 0);
    step("R9", 0, 1, 1, 1, 1, 1, 9'h1EE);     // return wins
    step("R9", 0, 1, 0, 1, 1, 1, 9'h1EE);     // call wins
    step("R9", 0, 1, 0, 0, 1, 1, 9'h1EE);     // jump wins
    step("R9", 0, 1, 0, 0, 0, 1, 9'h1EE);     // low write
    step("R2", 0, 1, 0, 0, 1, 0, 9'h1FE);
    step("R2", 0, 1, 0, 0, 0, 0, 0);
    step("R2", 0, 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 400; i++) begin
      int r = $urandom_range(0, 31);
      step("R9", r == 0, $urandom_range(0, 3) != 0, r[1] & r[2], r[2] & r[3],
           r[3], r[4], $urandom_range(0, 511));
    end
    step("R1", 1, 1, 0, 1, 0, 0, 9'h033);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule